// File: doc/BRIEF.md
# Buffered HDLC Register Interface

This block sits between a host processor and a pair of serial HDLC channels. On the host side it is a small bus slave: a 3-bit address, 8-bit data, and single read or write cycles marked by a strobe and answered one cycle later by an acknowledge. Behind it are a 128-byte transmit FIFO and a 128-byte receive FIFO. Status/control registers give these FIFOs frame semantics. The host fills the transmit FIFO and then starts the frame. It learns through a done flag and an interrupt when the channel has drained it. Each completed received frame is reported with a ready flag, an interrupt and a length register.

On the channel side, the transmit FIFO offers one byte at a time with a valid/take handshake. A flag marks the final byte of the frame, and a one-cycle pulse tells the serializer to send an abort. The receive channel pushes bytes with a valid strobe and closes a frame with an end pulse, which also carries the frame's error and abort status. The receive buffer holds one frame at a time. A frame that does not fit, or that arrives while the previous one is still unread, is discarded as a whole and flagged as overflow. Everything runs on one clock.

Top module: `hdlc_regbuf`

## Requirements
- R1: A bus access is taken when `bus_stb` is high and `bus_ack` is low. `bus_ack` is high in the next cycle and low in the cycle after. Read data is valid while `bus_ack` is high. Reads of address 1 and addresses 5 to 7 return 0.
- R2: After reset, the transmit status (address 0), the receive status (address 2) and the length (address 4) all read 0. Both interrupts are low.
- R3: While transmission is not enabled, each write to address 1 queues one byte, up to 128 bytes. A write to a full FIFO drops the byte and sets the transmit overflow flag, which is bit 4 of address 0.
- R4: Writing 1 to bit 1 of address 0 enables transmission. The queued bytes are then offered on `txc_data` in write order, and `txc_last` is high with the final byte. The cycle after the last byte is taken, the done flag (bit 0 of address 0) and `irq_tx_done` go high and transmission is disabled. Enabling also clears bits 3 and 4 of address 0.
- R5: A done flag that is set clears on the next write to address 1.
- R6: While transmission is enabled, writes to address 1 are ignored: the byte is never transmitted.
- R7: Writing 1 to bit 2 of address 0 empties the transmit FIFO, disables transmission, pulses `txc_abort` high for one cycle and sets the transmit aborted flag (bit 3 of address 0). It does not set done. When the same write also sets bit 1, the abort wins.
- R8: Each write to address 0 loads bit 5 into `txc_fcs_en`. Bits 1, 2 and 5 of address 0 always read 0.
- R9: An `rxc_end` pulse that closes a frame of at least one byte sets ready (bit 0 of address 2) and `irq_rx_ready`. It loads the byte count into address 4, and a byte pushed in the same cycle as the pulse counts. It captures `rxc_err` into bit 2 of address 2 and `rxc_abort` into bit 3.
- R10: While ready is set, reads of address 3 return the frame's bytes in order. Ready clears when the last byte is read. A read of address 3 while ready is low leaves the buffer unchanged.
- R11: Writing 1 to bit 1 of address 2 while ready is set discards the rest of the frame and clears ready.
- R12: A received byte that finds the buffer full, or that arrives while ready is set, sets the receive overflow flag (bit 4 of address 2). Its whole frame is then discarded and raises no ready, and a waiting frame is left intact. The next frame that completes clears the flag.
- R13: An `rxc_end` pulse that closes a frame of zero bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 3 | Register address |
| bus_wdat | input | 8 | Write data |
| bus_rdat | output | 8 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Access acknowledge |
| irq_tx_done | output | 1 | Transmit frame finished |
| irq_rx_ready | output | 1 | Received frame waiting |
| txc_data | output | 8 | Byte offered to the transmit channel |
| txc_valid | output | 1 | A byte is offered |
| txc_last | output | 1 | Offered byte ends the frame |
| txc_take | input | 1 | Channel takes the offered byte |
| txc_fcs_en | output | 1 | Check-sequence enable for the serializer |
| txc_abort | output | 1 | One-cycle abort request |
| rxc_data | input | 8 | Byte from the receive channel |
| rxc_valid | input | 1 | Byte strobe |
| rxc_end | input | 1 | Frame end pulse |
| rxc_err | input | 1 | Frame error status, sampled with the end pulse |
| rxc_abort | input | 1 | Frame aborted status, sampled with the end pulse |

## Verification
The bench drives the boundaries of both FIFOs. It queues 129 transmit bytes, so a design with an off-by-one full test would transmit a wrong byte count or miss the overflow flag. It receives a 129-byte frame, which such a design would report as ready. A stray receive byte arrives while a frame is waiting, and a design that appended it would return a corrupted length or byte order. Further scenarios cover a data write while enabled, a read before a frame is ready, a frame end with zero bytes, and a drop followed by a new frame. Any of these leaves a design with sloppy pointer or flag handling returning the wrong byte, a stale ready, or a done flag that never clears.

// File: rtl/hdlc_regbuf_pkg.sv
package hdlc_regbuf_pkg;
  localparam int DW = 8;
  localparam logic [2:0] ADR_TX_SC  = 3'd0;
  localparam logic [2:0] ADR_TX_DAT = 3'd1;
  localparam logic [2:0] ADR_RX_SC  = 3'd2;
  localparam logic [2:0] ADR_RX_DAT = 3'd3;
  localparam logic [2:0] ADR_RX_LEN = 3'd4;
  // transmit status/control bit positions
  localparam int TB_DONE  = 0;
  localparam int TB_EN    = 1;
  localparam int TB_ABORT = 2;
  localparam int TB_ABTD  = 3;
  localparam int TB_OVF   = 4;
  localparam int TB_FCS   = 5;
  // receive status/control bit positions
  localparam int RB_READY = 0;
  localparam int RB_DROP  = 1;
  localparam int RB_ERR   = 2;
  localparam int RB_ABTD  = 3;
  localparam int RB_OVF   = 4;
endpackage

// File: rtl/hdlc_rb_fifo.sv
module hdlc_rb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem[rd_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = wr_q;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = step(wr_q);
      if (do_pop)  rd_d = step(rd_q);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/hdlc_rb_tx.sv
module hdlc_rb_tx #(
  parameter int DEPTH = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          data_wr,
  input  logic [hdlc_regbuf_pkg::DW-1:0] wdata,
  input  logic                          ctl_wr,
  input  logic                          ctl_en,
  input  logic                          ctl_abort,
  input  logic                          ctl_fcs,
  input  logic                          take,
  output logic                          ch_valid,
  output logic [hdlc_regbuf_pkg::DW-1:0] ch_data,
  output logic                          ch_last,
  output logic                          ch_fcs_en,
  output logic                          ch_abort,
  output logic                          st_done,
  output logic                          st_aborted,
  output logic                          st_ovf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          en_q, en_d, done_q, done_d, abt_q, abt_d;
  logic          ovf_q, ovf_d, fcs_q, fcs_d, pls_q, pls_d;
  logic          full, empty, push, pop, flush;
  logic [CW-1:0] count;

  assign push  = data_wr && !en_q;
  assign pop   = take && en_q && !empty;
  assign flush = ctl_wr && ctl_abort;

  hdlc_rb_fifo #(.W(hdlc_regbuf_pkg::DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wdata), .pop(pop),
    .flush(flush), .dout(ch_data), .full(full), .empty(empty), .count(count)
  );

  always_comb begin
    en_d   = en_q;
    done_d = done_q;
    abt_d  = abt_q;
    ovf_d  = ovf_q;
    fcs_d  = fcs_q;
    pls_d  = 1'b0;
    if (push) begin
      done_d = 1'b0;
      if (full) ovf_d = 1'b1;
    end
    if (en_q && empty) begin
      en_d   = 1'b0;
      done_d = 1'b1;
    end
    if (ctl_wr) begin
      fcs_d = ctl_fcs;
      if (ctl_abort) begin
        en_d  = 1'b0;
        abt_d = 1'b1;
        pls_d = 1'b1;
      end else if (ctl_en) begin
        en_d  = 1'b1;
        abt_d = 1'b0;
        ovf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      abt_q  <= 1'b0;
      ovf_q  <= 1'b0;
      fcs_q  <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      abt_q  <= abt_d;
      ovf_q  <= ovf_d;
      fcs_q  <= fcs_d;
      pls_q  <= pls_d;
    end
  end

  assign ch_valid   = en_q && !empty;
  assign ch_last    = (count == CW'(1));
  assign ch_fcs_en  = fcs_q;
  assign ch_abort   = pls_q;
  assign st_done    = done_q;
  assign st_aborted = abt_q;
  assign st_ovf     = ovf_q;
endmodule

// File: rtl/hdlc_rb_rx.sv
module hdlc_rb_rx #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [hdlc_regbuf_pkg::DW-1:0] in_data,
  input  logic                          in_end,
  input  logic                          in_err,
  input  logic                          in_abort,
  input  logic                          cpu_pop,
  input  logic                          cpu_drop,
  output logic                          st_ready,
  output logic                          st_err,
  output logic                          st_abort,
  output logic                          st_ovf,
  output logic [CW-1:0]                 len,
  output logic [hdlc_regbuf_pkg::DW-1:0] rd_data
);
  logic          rdy_q, rdy_d, err_q, err_d, abt_q, abt_d;
  logic          ovf_q, ovf_d, lost_q, lost_d;
  logic [CW-1:0] flen_q, flen_d, len_q, len_d, count, cnt_end;
  logic          full, empty, push, pop, flush, miss, lost_now, drop_now;

  assign miss     = in_valid && (rdy_q || full);
  assign push     = in_valid && !rdy_q && !lost_q && !full;
  assign lost_now = lost_q || miss;
  assign cnt_end  = flen_q + CW'(push);
  assign pop      = cpu_pop && rdy_q && !empty;
  assign drop_now = cpu_drop && rdy_q;
  assign flush    = drop_now || (in_end && lost_now && !rdy_q);

  hdlc_rb_fifo #(.W(hdlc_regbuf_pkg::DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_data), .pop(pop),
    .flush(flush), .dout(rd_data), .full(full), .empty(empty), .count(count)
  );

  always_comb begin
    rdy_d  = rdy_q;
    err_d  = err_q;
    abt_d  = abt_q;
    ovf_d  = ovf_q;
    lost_d = lost_q;
    flen_d = flen_q;
    len_d  = len_q;
    if (push) flen_d = flen_q + 1'b1;
    if (miss) begin
      ovf_d  = 1'b1;
      lost_d = 1'b1;
    end
    if ((pop && count == CW'(1)) || drop_now) rdy_d = 1'b0;
    if (in_end) begin
      flen_d = '0;
      lost_d = 1'b0;
      if (!lost_now && cnt_end != '0) begin
        rdy_d = 1'b1;
        len_d = cnt_end;
        err_d = in_err;
        abt_d = in_abort;
        ovf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
      abt_q  <= 1'b0;
      ovf_q  <= 1'b0;
      lost_q <= 1'b0;
      flen_q <= '0;
      len_q  <= '0;
    end else begin
      rdy_q  <= rdy_d;
      err_q  <= err_d;
      abt_q  <= abt_d;
      ovf_q  <= ovf_d;
      lost_q <= lost_d;
      flen_q <= flen_d;
      len_q  <= len_d;
    end
  end

  assign st_ready = rdy_q;
  assign st_err   = err_q;
  assign st_abort = abt_q;
  assign st_ovf   = ovf_q;
  assign len      = len_q;
endmodule

// File: rtl/hdlc_regbuf.sv
module hdlc_regbuf
  import hdlc_regbuf_pkg::*;
#(
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [2:0]    bus_adr,
  input  logic [DW-1:0] bus_wdat,
  output logic [DW-1:0] bus_rdat,
  output logic          bus_ack,
  output logic          irq_tx_done,
  output logic          irq_rx_ready,
  output logic [DW-1:0] txc_data,
  output logic          txc_valid,
  output logic          txc_last,
  input  logic          txc_take,
  output logic          txc_fcs_en,
  output logic          txc_abort,
  input  logic [DW-1:0] rxc_data,
  input  logic          rxc_valid,
  input  logic          rxc_end,
  input  logic          rxc_err,
  input  logic          rxc_abort
);
  localparam int LW = $clog2(RX_DEPTH + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          ack_q, ack_d, acc, wr, rd;
  logic [DW-1:0] rdat_q, rdat_d, rmux;
  logic          tx_done, tx_abt, tx_ovf;
  logic          rx_rdy, rx_err, rx_abt, rx_ovf;
  logic [LW-1:0] rx_len;
  logic [DW-1:0] rx_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc = bus_stb && !ack_q;
  assign wr  = acc && bus_we;
  assign rd  = acc && !bus_we;

  hdlc_rb_tx #(.DEPTH(TX_DEPTH)) tx_i (
    .clk(clk), .rst_n(rst_int_n),
    .data_wr(wr && bus_adr == ADR_TX_DAT), .wdata(bus_wdat),
    .ctl_wr(wr && bus_adr == ADR_TX_SC), .ctl_en(bus_wdat[TB_EN]),
    .ctl_abort(bus_wdat[TB_ABORT]), .ctl_fcs(bus_wdat[TB_FCS]),
    .take(txc_take), .ch_valid(txc_valid), .ch_data(txc_data),
    .ch_last(txc_last), .ch_fcs_en(txc_fcs_en), .ch_abort(txc_abort),
    .st_done(tx_done), .st_aborted(tx_abt), .st_ovf(tx_ovf)
  );

  hdlc_rb_rx #(.DEPTH(RX_DEPTH)) rx_i (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(rxc_valid), .in_data(rxc_data), .in_end(rxc_end),
    .in_err(rxc_err), .in_abort(rxc_abort),
    .cpu_pop(rd && bus_adr == ADR_RX_DAT),
    .cpu_drop(wr && bus_adr == ADR_RX_SC && bus_wdat[RB_DROP]),
    .st_ready(rx_rdy), .st_err(rx_err), .st_abort(rx_abt), .st_ovf(rx_ovf),
    .len(rx_len), .rd_data(rx_byte)
  );

  always_comb begin
    rmux = '0;
    case (bus_adr)
      ADR_TX_SC: begin
        rmux[TB_DONE] = tx_done;
        rmux[TB_ABTD] = tx_abt;
        rmux[TB_OVF]  = tx_ovf;
      end
      ADR_RX_SC: begin
        rmux[RB_READY] = rx_rdy;
        rmux[RB_ERR]   = rx_err;
        rmux[RB_ABTD]  = rx_abt;
        rmux[RB_OVF]   = rx_ovf;
      end
      ADR_RX_DAT: rmux = rx_byte;
      ADR_RX_LEN: rmux = DW'(rx_len);
      default:    rmux = '0;
    endcase
  end

  always_comb begin
    ack_d  = acc;
    rdat_d = rd ? rmux : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= ack_d;
      rdat_q <= rdat_d;
    end
  end

  assign bus_ack      = ack_q;
  assign bus_rdat     = rdat_q;
  assign irq_tx_done  = tx_done;
  assign irq_rx_ready = rx_rdy;
endmodule

// File: rtl/hdlc_regbuf_chk.sv
module hdlc_regbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_stb,
  input logic       bus_we,
  input logic [2:0] bus_adr,
  input logic       bus_ack,
  input logic       irq_tx_done,
  input logic       irq_rx_ready,
  input logic       txc_valid,
  input logic       txc_abort,
  input logic       rxc_end
);
  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !bus_ack) |=> bus_ack);

  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_done_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx_done) |-> $past(bus_stb && bus_we && !bus_ack && bus_adr == 3'd1));

  assert_abort_stops_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txc_abort |-> !txc_valid);

  assert_ready_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx_ready) |-> $past(rxc_end));

  // R10 and R11: ready only falls through a data read or a drop write
  assert_ready_clear_by_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_rx_ready) |-> $past(bus_stb && !bus_ack && (bus_adr == 3'd2 || bus_adr == 3'd3)));
endmodule

bind hdlc_regbuf hdlc_regbuf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
  .bus_adr(bus_adr), .bus_ack(bus_ack), .irq_tx_done(irq_tx_done),
  .irq_rx_ready(irq_rx_ready), .txc_valid(txc_valid),
  .txc_abort(txc_abort), .rxc_end(rxc_end)
);

// File: tb/hdlc_regbuf_tb_top.sv
`timescale 1ns/1ps
module hdlc_regbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_stb, bus_we, bus_ack;
  logic [2:0] bus_adr;
  logic [7:0] bus_wdat, bus_rdat;
  logic       irq_tx_done, irq_rx_ready;
  logic [7:0] txc_data;
  logic       txc_valid, txc_last, txc_take, txc_fcs_en, txc_abort;
  logic [7:0] rxc_data;
  logic       rxc_valid, rxc_end, rxc_err, rxc_abort;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  hdlc_regbuf dut_i (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
    .bus_ack(bus_ack), .irq_tx_done(irq_tx_done), .irq_rx_ready(irq_rx_ready),
    .txc_data(txc_data), .txc_valid(txc_valid), .txc_last(txc_last),
    .txc_take(txc_take), .txc_fcs_en(txc_fcs_en), .txc_abort(txc_abort),
    .rxc_data(rxc_data), .rxc_valid(rxc_valid), .rxc_end(rxc_end),
    .rxc_err(rxc_err), .rxc_abort(rxc_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_adr = a; bus_wdat = d;
    @(negedge clk);
    chk("R1 write ack", bus_ack, 1'b1);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_adr = a;
    @(negedge clk);
    chk("R1 read ack", bus_ack, 1'b1);
    d = bus_rdat;
    bus_stb = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic e, input logic er, input logic ab);
    @(negedge clk);
    rxc_valid = 1'b1; rxc_data = d; rxc_end = e; rxc_err = er; rxc_abort = ab;
    @(negedge clk);
    rxc_valid = 1'b0; rxc_end = 1'b0; rxc_err = 1'b0; rxc_abort = 1'b0;
  endtask

  task automatic rx_end_only(input logic er, input logic ab);
    @(negedge clk);
    rxc_end = 1'b1; rxc_err = er; rxc_abort = ab;
    @(negedge clk);
    rxc_end = 1'b0; rxc_err = 1'b0; rxc_abort = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] d, input logic last, input string tag);
    @(negedge clk);
    chk({tag, " valid"}, txc_valid, 1'b1);
    chk({tag, " data"}, txc_data, d);
    chk({tag, " last"}, txc_last, last);
    txc_take = 1'b1;
    @(negedge clk);
    txc_take = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R2 irq_tx_done", irq_tx_done, 1'b0);
    chk("R2 irq_rx_ready", irq_rx_ready, 1'b0);
    bus_rd(3'd0, r); chk("R2 tx status", r, 8'h00);
    bus_rd(3'd2, r); chk("R2 rx status", r, 8'h00);
    bus_rd(3'd4, r); chk("R2 length", r, 8'h00);
    bus_rd(3'd6, r); chk("R1 unmapped read", r, 8'h00);
    @(negedge clk);
    chk("R1 ack drops", bus_ack, 1'b0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] r;
    bus_wr(3'd1, 8'hA1); bus_wr(3'd1, 8'hB2); bus_wr(3'd1, 8'hC3);
    bus_wr(3'd0, 8'h22);
    chk("R8 fcs enable out", txc_fcs_en, 1'b1);
    bus_rd(3'd0, r); chk("R8 write-only bits read 0", r, 8'h00);
    tx_take(8'hA1, 1'b0, "R4 byte0");
    tx_take(8'hB2, 1'b0, "R4 byte1");
    tx_take(8'hC3, 1'b1, "R4 byte2");
    @(negedge clk);
    chk("R4 irq done", irq_tx_done, 1'b1);
    chk("R4 no more bytes", txc_valid, 1'b0);
    bus_rd(3'd0, r); chk("R4 done bit", r, 8'h01);
  endtask

  task automatic t_tx_done_clear;
    logic [7:0] r;
    bus_wr(3'd1, 8'h5A);
    chk("R5 irq cleared", irq_tx_done, 1'b0);
    bus_rd(3'd0, r); chk("R5 done bit cleared", r, 8'h00);
  endtask

  task automatic t_tx_locked;
    bus_wr(3'd0, 8'h02);
    chk("R8 fcs enable off", txc_fcs_en, 1'b0);
    bus_wr(3'd1, 8'h55);
    tx_take(8'h5A, 1'b1, "R6 only queued byte");
    @(negedge clk);
    chk("R6 ignored byte not sent", txc_valid, 1'b0);
    chk("R6 done after one byte", irq_tx_done, 1'b1);
  endtask

  task automatic t_tx_full;
    logic [7:0] r;
    for (int i = 0; i < 129; i++) bus_wr(3'd1, 8'(i + 1));
    bus_rd(3'd0, r); chk("R3 tx overflow flag", r, 8'h10);
    bus_wr(3'd0, 8'h02);
    for (int i = 0; i < 128; i++) tx_take(8'(i + 1), (i == 127), "R3 queued byte");
    @(negedge clk);
    chk("R3 129th byte dropped", txc_valid, 1'b0);
    bus_rd(3'd0, r); chk("R4 done and overflow cleared by enable", r, 8'h01);
  endtask

  task automatic t_tx_abort;
    logic [7:0] r;
    bus_wr(3'd1, 8'h11); bus_wr(3'd1, 8'h22);
    bus_wr(3'd0, 8'h06);
    chk("R7 abort pulse", txc_abort, 1'b1);
    chk("R7 not transmitting", txc_valid, 1'b0);
    @(negedge clk);
    chk("R7 pulse one cycle", txc_abort, 1'b0);
    bus_rd(3'd0, r); chk("R7 aborted flag", r, 8'h08);
    chk("R7 no done", irq_tx_done, 1'b0);
    bus_wr(3'd0, 8'h02);
    bus_rd(3'd0, r); chk("R7 fifo emptied, done at once", r, 8'h01);
  endtask

  task automatic t_rx_basic;
    logic [7:0] r;
    rx_push(8'h10, 1'b0, 1'b0, 1'b0);
    rx_push(8'h20, 1'b0, 1'b0, 1'b0);
    chk("R9 no ready mid frame", irq_rx_ready, 1'b0);
    rx_push(8'h30, 1'b1, 1'b1, 1'b0);
    chk("R9 irq ready", irq_rx_ready, 1'b1);
    bus_rd(3'd2, r); chk("R9 ready and error", r, 8'h05);
    bus_rd(3'd4, r); chk("R9 length incl end byte", r, 8'd3);
    bus_rd(3'd3, r); chk("R10 byte0", r, 8'h10);
    bus_rd(3'd3, r); chk("R10 byte1", r, 8'h20);
    chk("R10 ready held", irq_rx_ready, 1'b1);
    bus_rd(3'd3, r); chk("R10 byte2", r, 8'h30);
    chk("R10 ready cleared", irq_rx_ready, 1'b0);
    bus_rd(3'd2, r); chk("R10 status after drain", r, 8'h04);
    bus_rd(3'd3, r);
  endtask

  task automatic t_rx_early_read;
    logic [7:0] r;
    rx_push(8'h77, 1'b0, 1'b0, 1'b0);
    bus_rd(3'd3, r);
    rx_end_only(1'b0, 1'b1);
    bus_rd(3'd2, r); chk("R9 aborted flag", r, 8'h09);
    bus_rd(3'd4, r); chk("R10 early read kept length", r, 8'd1);
    bus_rd(3'd3, r); chk("R10 early read kept byte", r, 8'h77);
    bus_rd(3'd2, r); chk("R10 status", r, 8'h08);
  endtask

  task automatic t_rx_drop;
    logic [7:0] r;
    rx_push(8'h31, 1'b0, 1'b0, 1'b0);
    rx_push(8'h32, 1'b1, 1'b0, 1'b0);
    bus_rd(3'd2, r); chk("R11 ready before drop", r, 8'h01);
    bus_wr(3'd2, 8'h02);
    chk("R11 irq after drop", irq_rx_ready, 1'b0);
    bus_rd(3'd2, r); chk("R11 status after drop", r, 8'h00);
    rx_push(8'h99, 1'b1, 1'b0, 1'b0);
    bus_rd(3'd4, r); chk("R11 next length", r, 8'd1);
    bus_rd(3'd3, r); chk("R11 dropped bytes gone", r, 8'h99);
  endtask

  task automatic t_rx_overflow;
    logic [7:0] r;
    for (int i = 0; i < 129; i++) rx_push(8'(i), 1'b0, 1'b0, 1'b0);
    rx_end_only(1'b0, 1'b0);
    chk("R12 long frame no ready", irq_rx_ready, 1'b0);
    bus_rd(3'd2, r); chk("R12 overflow flag", r, 8'h10);
    bus_rd(3'd4, r); chk("R12 length untouched", r, 8'd1);
    rx_push(8'h42, 1'b0, 1'b0, 1'b0);
    rx_push(8'h43, 1'b1, 1'b0, 1'b0);
    bus_rd(3'd2, r); chk("R12 good frame clears overflow", r, 8'h01);
    rx_push(8'hEE, 1'b0, 1'b0, 1'b0);
    bus_rd(3'd2, r); chk("R12 byte while ready", r, 8'h11);
    bus_rd(3'd4, r); chk("R12 waiting length intact", r, 8'd2);
    bus_rd(3'd3, r); chk("R12 waiting byte0", r, 8'h42);
    bus_rd(3'd3, r); chk("R12 waiting byte1", r, 8'h43);
    rx_end_only(1'b0, 1'b0);
    chk("R12 lost frame no ready", irq_rx_ready, 1'b0);
    bus_rd(3'd2, r); chk("R12 overflow held", r, 8'h10);
  endtask

  task automatic t_rx_empty_end;
    logic [7:0] r;
    rx_end_only(1'b1, 1'b1);
    chk("R13 empty frame ignored", irq_rx_ready, 1'b0);
    bus_rd(3'd2, r); chk("R13 status unchanged", r, 8'h10);
    rx_push(8'h5C, 1'b1, 1'b0, 1'b0);
    bus_rd(3'd4, r); chk("R13 next length", r, 8'd1);
    bus_rd(3'd3, r); chk("R13 next byte", r, 8'h5C);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_stb = 1'b0; bus_we = 1'b0; bus_adr = '0; bus_wdat = '0;
    txc_take = 1'b0;
    rxc_data = '0; rxc_valid = 1'b0; rxc_end = 1'b0; rxc_err = 1'b0; rxc_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_done_clear();
    t_tx_locked();
    t_tx_full();
    t_tx_abort();
    t_rx_basic();
    t_rx_early_read();
    t_rx_drop();
    t_rx_overflow();
    t_rx_empty_end();
    v = 8'h00;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule